// File: doc/BRIEF.md
# External Program-Fetch Bus Controller

This block connects a small controller's instruction-fetch path to program memory over a narrow pin budget. A fetch request carries a 16-bit code address, which reaches a full 64 KB space. When external code is selected, the low address byte and the returned instruction byte share one byte-wide port and are separated in time. The high address byte has a port of its own and keeps the upper address bits for the whole access. While the address-strobe output `ale` is high, the low port carries address bits 7..0, and a board-level transparent latch captures them. The controller then lowers the strobe, holds the address for one more cycle and releases the port. After that it pulls the active-low fetch-enable `fetch_en_n` low. This output drives the memory's output-enable pin, and the memory answers on the low port. The byte present on the last enable cycle becomes the response.

A select input, `ext_code_n`, is active low. When it is low, fetches go to external memory. When it is high, they go to internal code memory through a simple one-cycle read port, and the external strobes stay idle. The fetch request and the returned byte each use valid/ready handshakes. A request is accepted only when `req_valid` and `req_ready` are both high at a clock edge. `req_ready` is low while an access is in progress and while an earlier response has not yet been taken. A response is presented with `rsp_valid` and holds until `rsp_ready` is seen high at an edge. Only one fetch is ever outstanding, so back-pressure on the response stops further requests from being accepted.

Top module: `xmem_fetch_ctrl`

## Requirements
- R1: While reset is held and after it is released, `ale`=0, `fetch_en_n`=1, `lo_oe`=0, `int_rd`=0, `rsp_valid`=0 and `req_ready`=1.
- R2: For an external fetch (`ext_code_n`=0 when the request is accepted), `ale` is high for exactly ALE_CYC cycles, starting in the cycle after acceptance. During those cycles `lo_oe`=1 and `lo_out` equals address bits 7..0.
- R3: `hi_addr` equals address bits 15..8 in every cycle where `ale` is high or `fetch_en_n` is low.
- R4: After `ale` falls, `lo_oe` stays high for exactly one cycle. It is then low for one cycle in which `fetch_en_n` is still high. `lo_oe` is never high while `fetch_en_n` is low.
- R5: During an external fetch, `fetch_en_n` is low for exactly PSEN_CYC consecutive cycles. The value on `lo_in` in the last of them is returned as `rsp_data`, and `rsp_valid` rises ALE_CYC+PSEN_CYC+2 clock edges after the acceptance edge.
- R6: For an internal fetch (`ext_code_n`=1 when the request is accepted), `ale` stays 0 and `fetch_en_n` stays 1. `int_rd` is high for one cycle with `int_addr` equal to the request address. `int_rdata` from that cycle is returned with `rsp_valid` rising one edge after the acceptance edge.
- R7: While `rsp_valid`=1 and `rsp_ready`=0, both `rsp_valid` and `rsp_data` hold, and `req_ready`=0. `rsp_valid` falls after the edge on which `rsp_ready` is seen high.
- R8: `ext_code_n` is sampled only when a request is accepted. Changing it during an access does not change that access's path, timing or data.
- R9: Addresses 0x0000 and 0xFFFF are fetched correctly on both the external and the internal path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_code_n | input | 1 | 0: external code memory, 1: internal; sampled at request acceptance |
| req_valid | input | 1 | Fetch request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_addr | input | 16 | Fetch address |
| rsp_valid | output | 1 | Fetched byte valid |
| rsp_ready | input | 1 | Consumer takes the byte |
| rsp_data | output | 8 | Fetched instruction byte |
| lo_out | output | 8 | Low port output value (address bits 7..0) |
| lo_oe | output | 1 | Low port output enable; 0 releases the port |
| lo_in | input | 8 | Low port input value (data from memory) |
| hi_addr | output | 8 | High port, address bits 15..8 |
| ale | output | 1 | Address strobe, high while the low port carries address |
| fetch_en_n | output | 1 | Active-low program fetch enable to memory output-enable |
| int_rd | output | 1 | Internal code memory read strobe |
| int_addr | output | 16 | Internal code memory address |
| int_rdata | input | 8 | Internal code memory data, used in the `int_rd` cycle |

## Verification
Counting the acceptance edge as edge 0, an external result is due at edge 7 with the default counts (ALE_CYC+PSEN_CYC+2), and an internal result is due at edge 1. The bench samples on falling edges. It counts falling edges from acceptance, so `rsp_valid` is expected at the 8th falling edge for external fetches and the 2nd for internal ones. At each of those falling edges it also checks the strobe and port phase expected for that position. A queue holds the expected bytes, and a monitor compares them at the rising edge where the response handshake completes.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ADDR  = 3'd1,
    PH_HOLD  = 3'd2,
    PH_FLOAT = 3'd3,
    PH_DATA  = 3'd4,
    PH_INT   = 3'd5
  } phase_t;
endpackage

// File: rtl/xmem_seq.sv
module xmem_seq
  import xmem_pkg::*;
#(
  parameter int ALE_CYC  = 2,
  parameter int PSEN_CYC = 3
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   start_ext,
  output phase_t phase,
  output logic   fin_ext,
  output logic   fin_int
);
  localparam int MAXC = (ALE_CYC > PSEN_CYC) ? ALE_CYC : PSEN_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] ALE_LAST  = CW'(ALE_CYC - 1);
  localparam logic [CW-1:0] DATA_LAST = CW'(PSEN_CYC - 1);

  phase_t        phase_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      case (phase_q)
        PH_IDLE: if (start) begin
          phase_q <= start_ext ? PH_ADDR : PH_INT;
          cnt_q   <= '0;
        end
        PH_ADDR: begin
          if (cnt_q == ALE_LAST) begin
            phase_q <= PH_HOLD;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_HOLD:  phase_q <= PH_FLOAT;
        PH_FLOAT: begin
          phase_q <= PH_DATA;
          cnt_q   <= '0;
        end
        PH_DATA: begin
          if (cnt_q == DATA_LAST) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_INT:  phase_q <= PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase   = phase_q;
  assign fin_ext = (phase_q == PH_DATA) && (cnt_q == DATA_LAST);
  assign fin_int = (phase_q == PH_INT);

  // R2: the address phase never outlasts its programmed count
  p_addr_cnt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_ADDR) |-> (cnt_q <= ALE_LAST));
  // R5: the data phase is always entered through the float cycle
  p_data_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_q == PH_DATA) && (cnt_q == '0)) |-> ($past(phase_q) == PH_FLOAT));
endmodule

// File: rtl/xmem_rsp_reg.sv
module xmem_rsp_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] din,
  input  logic          take,
  output logic          valid,
  output logic [DW-1:0] dout
);
  logic          v_q;
  logic [DW-1:0] d_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_q <= 1'b0;
      d_q <= '0;
    end else if (load) begin
      v_q <= 1'b1;
      d_q <= din;
    end else if (take) begin
      v_q <= 1'b0;
    end
  end

  assign valid = v_q;
  assign dout  = d_q;

  // R7: an unaccepted response holds its value
  p_rsp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (v_q && !take) |=> (v_q && $stable(d_q)));
endmodule

// File: rtl/xmem_fetch_ctrl.sv
module xmem_fetch_ctrl
  import xmem_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 8,
  parameter int ALE_CYC  = 2,
  parameter int PSEN_CYC = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_code_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_data,
  output logic [DW-1:0] lo_out,
  output logic          lo_oe,
  input  logic [DW-1:0] lo_in,
  output logic [AW-DW-1:0] hi_addr,
  output logic          ale,
  output logic          fetch_en_n,
  output logic          int_rd,
  output logic [AW-1:0] int_addr,
  input  logic [DW-1:0] int_rdata
);
  localparam int HW = AW - DW;

  phase_t        phase;
  logic          fin_ext, fin_int, accept;
  logic [AW-1:0] addr_q;

  assign req_ready = (phase == PH_IDLE) && !rsp_valid;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) addr_q <= '0;
    else if (accept) addr_q <= req_addr;
  end

  xmem_seq #(.ALE_CYC(ALE_CYC), .PSEN_CYC(PSEN_CYC)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(accept), .start_ext(!ext_code_n),
    .phase(phase), .fin_ext(fin_ext), .fin_int(fin_int)
  );

  // Bus drive decoded from the phase register
  assign ale        = (phase == PH_ADDR);
  assign lo_oe      = (phase == PH_ADDR) || (phase == PH_HOLD);
  assign lo_out     = addr_q[DW-1:0];
  assign hi_addr    = addr_q[AW-1:DW];
  assign fetch_en_n = (phase != PH_DATA);
  assign int_rd     = (phase == PH_INT);
  assign int_addr   = addr_q;

  xmem_rsp_reg #(.DW(DW)) u_rsp (
    .clk(clk), .rst_n(rst_n), .load(fin_ext || fin_int),
    .din(fin_ext ? lo_in : int_rdata), .take(rsp_ready),
    .valid(rsp_valid), .dout(rsp_data)
  );

  // R4: the low port is never driven while memory is enabled
  p_no_contention_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_en_n |-> !lo_oe);
  // R4: a float cycle precedes every fetch-enable assertion
  p_float_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fetch_en_n) |-> !$past(lo_oe));
  // R2: the strobe only rises with the address driven
  p_ale_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> lo_oe);
  // R3: the high address byte holds while memory is enabled
  p_hi_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_en_n |-> $stable(hi_addr));
  // R6: internal reads keep the external strobes idle
  p_int_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int_rd |-> (!ale && fetch_en_n && !lo_oe));
  // R7: no new request is taken while a response waits
  p_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
  // R7: the response is withdrawn after it is taken
  p_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready) |=> !rsp_valid);
endmodule

// File: tb/tb_xmem_fetch_ctrl.sv
`timescale 1ns/1ps
module tb_xmem_fetch_ctrl;
  localparam int ALE_CYC  = 2;
  localparam int PSEN_CYC = 3;
  localparam int EXT_LAT  = ALE_CYC + PSEN_CYC + 3; // falling edges after acceptance
  localparam int INT_LAT  = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ext_code_n = 1'b0, req_valid = 1'b0, rsp_ready = 1'b1;
  logic [15:0] req_addr = '0;
  logic req_ready, rsp_valid, lo_oe, ale, fetch_en_n, int_rd;
  logic [7:0] rsp_data, lo_out, lo_in, hi_addr, int_rdata, lat_lo;
  logic [15:0] int_addr;

  always #4 clk = ~clk;

  xmem_fetch_ctrl #(.ALE_CYC(ALE_CYC), .PSEN_CYC(PSEN_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .ext_code_n(ext_code_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .lo_out(lo_out), .lo_oe(lo_oe), .lo_in(lo_in), .hi_addr(hi_addr),
    .ale(ale), .fetch_en_n(fetch_en_n), .int_rd(int_rd),
    .int_addr(int_addr), .int_rdata(int_rdata)
  );

  function automatic logic [7:0] ext_rom(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
  endfunction
  function automatic logic [7:0] int_rom(input logic [15:0] a);
    return ~a[7:0] + a[15:8];
  endfunction

  // Board model: strobe-gated transparent latch and external ROM
  always_latch if (ale) lat_lo = lo_out;
  assign lo_in     = fetch_en_n ? 8'hFF : ext_rom({hi_addr, lat_lo});
  assign int_rdata = int_rom(int_addr);

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitor: compare each delivered byte with the scoreboard
  always @(posedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) check(1'b0, "R5/R6 unexpected response", rsp_data, 0);
      else begin
        automatic logic [7:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(rsp_data == e, t, rsp_data, e);
      end
    end
  end

  task automatic fetch(input logic [15:0] a, input bit ext, input int hold,
                       input bit flip, input string tag);
    int k, n_ale, n_en, n_int, bad_lo, bad_hi, clash, bad_int, bad_ph;
    logic [7:0] d0;
    n_ale = 0; n_en = 0; n_int = 0; bad_lo = 0; bad_hi = 0;
    clash = 0; bad_int = 0; bad_ph = 0;
    exp_q.push_back(ext ? ext_rom(a) : int_rom(a));
    tag_q.push_back(tag);
    @(negedge clk);
    check(req_ready, "R7 idle ready", req_ready, 1);
    req_valid = 1'b1; req_addr = a; ext_code_n = !ext; rsp_ready = (hold == 0);
    @(negedge clk);
    req_valid = 1'b0;
    k = 1;
    forever begin
      if (flip && k == 1) ext_code_n = ext;   // R8: flip the select mid-access
      n_ale += ale; n_en += !fetch_en_n; n_int += int_rd;
      if (ale && (lo_out != a[7:0] || !lo_oe)) bad_lo++;
      if ((ale || !fetch_en_n) && hi_addr != a[15:8]) bad_hi++;
      if (!fetch_en_n && lo_oe) clash++;
      if (int_rd && int_addr != a) bad_int++;
      if (ext && k == ALE_CYC + 1 && (ale || !lo_oe)) bad_ph++;
      if (ext && k == ALE_CYC + 2 && (lo_oe || !fetch_en_n)) bad_ph++;
      if (rsp_valid || k > 40) break;
      @(negedge clk);
      k++;
    end
    if (ext) begin
      check(k == EXT_LAT, {tag, " R5 latency"}, k, EXT_LAT);
      check(n_ale == ALE_CYC && bad_lo == 0, {tag, " R2 strobe cycles"}, n_ale, ALE_CYC);
      check(n_en == PSEN_CYC, {tag, " R5 enable cycles"}, n_en, PSEN_CYC);
      check(bad_hi == 0, {tag, " R3 high port"}, bad_hi, 0);
      check(clash == 0 && bad_ph == 0, {tag, " R4 turnaround"}, clash + bad_ph, 0);
    end else begin
      check(k == INT_LAT, {tag, " R6 latency"}, k, INT_LAT);
      check(n_ale == 0 && n_en == 0, {tag, " R6 strobes idle"}, n_ale + n_en, 0);
      check(n_int == 1 && bad_int == 0, {tag, " R6 internal read"}, n_int, 1);
    end
    d0 = rsp_data;
    for (int h = 0; h < hold; h++) begin
      check(rsp_valid && !req_ready && rsp_data == d0, {tag, " R7 back-pressure"},
            rsp_data, d0);
      @(negedge clk);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    check(!rsp_valid && req_ready, {tag, " R7 release"}, rsp_valid, 0);
    ext_code_n = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!ale && fetch_en_n && !lo_oe && !int_rd && !rsp_valid && req_ready,
          "R1 during reset", {ale, fetch_en_n, lo_oe, int_rd, rsp_valid, req_ready}, 6'b010001);
    rst_n = 1'b1;
    @(negedge clk);
    check(!ale && fetch_en_n && !lo_oe && !int_rd && !rsp_valid && req_ready,
          "R1 after reset", {ale, fetch_en_n, lo_oe, int_rd, rsp_valid, req_ready}, 6'b010001);
    fetch(16'h1234, 1'b1, 0, 1'b0, "R5 ext 1234");
    fetch(16'h0000, 1'b1, 0, 1'b0, "R9 ext 0000");
    fetch(16'hFFFF, 1'b1, 0, 1'b0, "R9 ext FFFF");
    fetch(16'hABCD, 1'b0, 0, 1'b0, "R6 int ABCD");
    fetch(16'h0000, 1'b0, 0, 1'b0, "R9 int 0000");
    fetch(16'hFFFF, 1'b0, 0, 1'b0, "R9 int FFFF");
    fetch(16'h5A3C, 1'b1, 3, 1'b0, "R7 ext hold");
    fetch(16'h0F0F, 1'b0, 2, 1'b0, "R7 int hold");
    fetch(16'h8001, 1'b1, 0, 1'b1, "R8 ext flip");
    fetch(16'h7FFE, 1'b0, 0, 1'b1, "R8 int flip");
    for (int i = 0; i < 6; i++)
      fetch(16'h2468 + 16'(i * 16'h1111), (i % 2) == 0, i % 3, 1'b0, "R2 mixed");
    repeat (2) @(negedge clk);
    check(exp_q.size() == 0, "R5/R6 all responses seen", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule